// File: doc/BRIEF.md
# Clocked Pseudo-Static RAM Burst-Write Port

This block is the device-side write path of a clocked pseudo-static RAM. A host opens a cycle by pulling chip-select low. It presents a word address with the address-valid strobe low and write-enable low. After a programmable number of clocks it streams a fixed-length run of 16-bit words. The block latches the address on the first clock edge of the strobe and counts the latency. It drives a three-state WAIT indicator so the host knows when data is taken. It then stores each beat into a small register array, honouring the upper and lower byte enables separately on every beat.

The beat address advances by one word per beat and wraps inside the block of words aligned to the burst length. Two protocol guards run beside the datapath. One flags a new strobe that arrives while a burst is still running. The other flags a chip-select window that stays open longer than a configured number of clocks. Both flags are sticky until reset. A combinational read port exposes the array contents.

Top module: `psram_burst_wr`

## Requirements
- R1: A burst starts on a rising edge with cs_n, adv_n and we_n all low, where the previous edge did not see cs_n and adv_n both low. The address is latched only at that edge. Later edges with adv_n still held low neither restart the burst nor re-latch the address.
- R2: Let the start edge be edge 0. The data beats are sampled on edges LATENCY to LATENCY+BURST_LEN-1 (defaults 5 and 4, so edges 5 to 8).
- R3: wait_oe equals the inverse of cs_n at all times, so WAIT is released (high impedance) whenever chip-select is high.
- R4: wait_o is low (not ready) while adv_n is low, and from the start edge until edge LATENCY-1. It rises after edge LATENCY-1 and stays high until chip-select goes high.
- R5: On each beat, ub_n high leaves bits 15:8 of the target word unchanged and lb_n high leaves bits 7:0 unchanged. Both high masks the whole beat.
- R6: Beat k writes the word at (base with its low log2(BURST_LEN) bits replaced by (base+k) mod BURST_LEN).
- R7: cs_n high on any edge ends the burst at once. Beats written earlier are kept, and no later beat of that burst is written.
- R8: A fresh strobe (as in R1, with cs_n low) seen while a burst is active is ignored. The running burst continues unchanged, and proto_err goes high and stays high until reset.
- R9: When cs_n stays low for TMO_CYCLES edges after a start edge (default 125, i.e. 2.5 us at 50 MHz), tmo_err goes high and stays high until reset.
- R10: A strobe edge with we_n high starts no burst and writes nothing.
- R11: After reset the array holds zero in every word, and wait_o, proto_err and tmo_err are low.
- R12: rd_data shows the word at rd_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| addr | input | ADDR_W | Word address, sampled at the start edge |
| din | input | 16 | Write data word |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 16 | Array word at rd_addr |
| wait_o | output | 1 | WAIT level: 0 not ready, 1 ready |
| wait_oe | output | 1 | WAIT drive enable; 0 means high impedance |
| proto_err | output | 1 | Sticky overlapping-burst error |
| tmo_err | output | 1 | Sticky over-long burst error |

## Verification
The bench drives a strobe held low for three edges with the address changed after the first edge. A design that treats each low edge as a start would re-latch and scatter the data. It starts at the third word of a block, so the addresses must wrap, and masks one byte on one beat and both bytes on the next. A design that applies masks per burst, or that forgets the wrap, corrupts neighbouring words. It drops chip-select after two beats, where a design that finishes the burst anyway writes two extra words. It also re-asserts the strobe in the middle of the latency, where a wrong design restarts and loses its base. It holds chip-select low past the limit to catch an off-by-one timeout count. The WAIT level and enable are compared against the model on every clock, so a ready edge one cycle early or late shows at once.

// File: rtl/psbw_pkg.sv
package psbw_pkg;
   localparam int WORD_W = 16;
   localparam int LANES  = WORD_W / 8;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [LANES-1:0]  lane_t;
endpackage

// File: rtl/psbw_seq.sv
module psbw_seq #(
   parameter int AW  = 4,
   parameter int LAT = 5,
   parameter int BL  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          adv_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   output logic          busy,
   output logic          start,
   output logic          ready,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic          proto_err
);
   localparam int CW = $clog2(LAT + BL + 1);
   localparam int BW = $clog2(BL);
   localparam logic [CW-1:0] C_RDY   = CW'(LAT - 1);
   localparam logic [CW-1:0] C_FIRST = CW'(LAT);
   localparam logic [CW-1:0] C_LAST  = CW'(LAT + BL - 1);

   logic          adv_q;
   logic          busy_q;
   logic [CW-1:0] cyc_q;
   logic [AW-1:0] base_q;
   logic          ready_q;
   logic          proto_q;
   logic          fresh;
   logic          in_data;
   logic [BW-1:0] beat;
   logic [BW-1:0] low_sum;

   assign fresh   = !cs_n && !adv_n && !adv_q;
   assign start   = fresh && !we_n && !busy_q;
   assign in_data = busy_q && (cyc_q >= C_FIRST) && (cyc_q <= C_LAST);
   assign beat    = BW'(cyc_q - C_FIRST);
   assign low_sum = base_q[BW-1:0] + beat;
   assign wr_en   = !cs_n && in_data;
   assign wr_addr = {base_q[AW-1:BW], low_sum};

   assign busy      = busy_q;
   assign ready     = ready_q;
   assign proto_err = proto_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adv_q   <= 1'b0;
         busy_q  <= 1'b0;
         cyc_q   <= '0;
         base_q  <= '0;
         ready_q <= 1'b0;
         proto_q <= 1'b0;
      end else begin
         adv_q <= !cs_n && !adv_n;
         if (cs_n) begin
            busy_q  <= 1'b0;
            ready_q <= 1'b0;
         end else if (busy_q) begin
            if (fresh) proto_q <= 1'b1;
            if (cyc_q == C_RDY) ready_q <= 1'b1;
            if (cyc_q == C_LAST) busy_q <= 1'b0;
            cyc_q <= cyc_q + 1'b1;
         end else if (start) begin
            busy_q  <= 1'b1;
            cyc_q   <= CW'(1);
            base_q  <= addr;
            ready_q <= 1'b0;
         end
      end
   end

   // R1: an ongoing burst never re-latches its base address
   p_no_relatch_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !cs_n) |=> $stable(base_q));
   // R4: chip-select high drops the ready level at the next edge
   p_ready_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !ready_q);
   // R8: the overlap flag is sticky
   p_proto_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      proto_q |=> proto_q);
endmodule

// File: rtl/psbw_guard.sv
module psbw_guard #(
   parameter int TMO = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic start,
   output logic tmo_err
);
   generate
      if (TMO > 0) begin : g_timer
         localparam int TW = $clog2(TMO + 1);
         localparam logic [TW-1:0] T_MAX  = TW'(TMO);
         localparam logic [TW-1:0] T_LAST = TW'(TMO - 1);

         logic          tact_q;
         logic [TW-1:0] tcnt_q;
         logic          err_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tact_q <= 1'b0;
               tcnt_q <= '0;
               err_q  <= 1'b0;
            end else if (cs_n) begin
               tact_q <= 1'b0;
            end else if (start) begin
               tact_q <= 1'b1;
               tcnt_q <= '0;
            end else if (tact_q && tcnt_q != T_MAX) begin
               tcnt_q <= tcnt_q + 1'b1;
               if (tcnt_q == T_LAST) err_q <= 1'b1;
            end
         end

         assign tmo_err = err_q;

         // R9: the timeout flag is sticky
         p_tmo_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            err_q |=> err_q);
      end else begin : g_no_timer
         assign tmo_err = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/psbw_array.sv
module psbw_array
   import psbw_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  lane_t         lane_n,
   input  word_t         din,
   input  logic [AW-1:0] rd_addr,
   output word_t         rd_data
);
   localparam int DEPTH = 1 << AW;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [7:0] bank [DEPTH];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
            end else if (wr_en && !lane_n[l]) begin
               bank[wr_addr] <= din[8*l +: 8];
            end
         end

         assign rd_data[8*l +: 8] = bank[rd_addr];
      end
   endgenerate
endmodule

// File: rtl/psram_burst_wr.sv
module psram_burst_wr
   import psbw_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int LATENCY    = 5,
   parameter int BURST_LEN  = 4,
   parameter int TMO_CYCLES = 125
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              adv_n,
   input  logic              we_n,
   input  logic              ub_n,
   input  logic              lb_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       din,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [15:0]       rd_data,
   output logic              wait_o,
   output logic              wait_oe,
   output logic              proto_err,
   output logic              tmo_err
);
   localparam int BW = $clog2(BURST_LEN);

   generate
      if (LATENCY < 2) begin : g_bad_lat
         $error("LATENCY must be at least 2");
      end
      if (BURST_LEN < 2 || (1 << BW) != BURST_LEN) begin : g_bad_bl
         $error("BURST_LEN must be a power of two, at least 2");
      end
      if (ADDR_W <= BW) begin : g_bad_aw
         $error("ADDR_W must exceed log2(BURST_LEN)");
      end
      if (WORD_W != 16) begin : g_bad_w
         $error("word width must be 16");
      end
   endgenerate

   logic              busy;
   logic              start;
   logic              ready;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;

   psbw_seq #(.AW(ADDR_W), .LAT(LATENCY), .BL(BURST_LEN)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .adv_n     (adv_n),
      .we_n      (we_n),
      .addr      (addr),
      .busy      (busy),
      .start     (start),
      .ready     (ready),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .proto_err (proto_err)
   );

   psbw_guard #(.TMO(TMO_CYCLES)) guard_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .start   (start),
      .tmo_err (tmo_err)
   );

   psbw_array #(.AW(ADDR_W)) array_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .lane_n  ({ub_n, lb_n}),
      .din     (din),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   assign wait_oe = !cs_n;
   assign wait_o  = ready && adv_n;

   // R2: no beat is stored before the ready level is up
   p_beat_after_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (ready && busy));
   // R6: consecutive beats step by one word inside the aligned block
   p_wrap_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |->
         (wr_addr[BW-1:0] == BW'($past(wr_addr[BW-1:0]) + 1'b1)
          && wr_addr[ADDR_W-1:BW] == $past(wr_addr[ADDR_W-1:BW])));
   // R7: nothing is stored while chip-select is high
   p_no_write_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !cs_n);
endmodule

// File: tb/psram_burst_wr_tb_top.sv
module psram_burst_wr_tb_top;
   localparam int AW  = 4;
   localparam int LAT = 5;
   localparam int BL  = 4;
   localparam int TMO = 125;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1;
   logic          adv_n = 1'b1;
   logic          we_n = 1'b1;
   logic          ub_n = 1'b1;
   logic          lb_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [15:0]   din = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [15:0]   rd_data;
   logic          wait_o;
   logic          wait_oe;
   logic          proto_err;
   logic          tmo_err;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   psram_burst_wr #(.ADDR_W(AW), .LATENCY(LAT), .BURST_LEN(BL), .TMO_CYCLES(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n),
      .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .din(din), .rd_addr(rd_addr),
      .rd_data(rd_data), .wait_o(wait_o), .wait_oe(wait_oe),
      .proto_err(proto_err), .tmo_err(tmo_err)
   );

   // behavioural reference model
   logic [15:0] mm [16];
   bit m_adv, m_busy, m_ready, m_proto, m_tmo, m_tact;
   int m_cyc, m_base, m_tcnt;

   initial for (int i = 0; i < 16; i++) mm[i] = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mm[i] = '0;
         m_adv = 0; m_busy = 0; m_ready = 0; m_proto = 0; m_tmo = 0;
         m_tact = 0; m_cyc = 0; m_base = 0; m_tcnt = 0;
      end else begin
         bit fresh, started;
         fresh = !cs_n && !adv_n && !m_adv;
         started = 0;
         if (cs_n) begin
            m_busy = 0; m_ready = 0;
         end else if (m_busy) begin
            if (fresh) m_proto = 1;
            if (m_cyc >= LAT && m_cyc < LAT + BL) begin
               int wa;
               wa = (m_base & ~(BL - 1)) | ((m_base + m_cyc - LAT) & (BL - 1));
               if (!ub_n) mm[wa][15:8] = din[15:8];
               if (!lb_n) mm[wa][7:0]  = din[7:0];
            end
            if (m_cyc == LAT - 1) m_ready = 1;
            if (m_cyc == LAT + BL - 1) m_busy = 0;
            m_cyc++;
         end else if (fresh && !we_n) begin
            m_busy = 1; m_cyc = 1; m_base = int'(addr); m_ready = 0; started = 1;
         end
         if (cs_n) m_tact = 0;
         else if (started) begin m_tact = 1; m_tcnt = 0; end
         else if (m_tact && m_tcnt < TMO) begin
            m_tcnt++;
            if (m_tcnt == TMO) m_tmo = 1;
         end
         m_adv = !cs_n && !adv_n;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-clock comparison of the WAIT pins and flags
   always @(negedge clk) begin
      if (rst_n) begin
         chk(wait_oe == !cs_n, "R3 wait_oe", 32'(wait_oe), 32'(!cs_n));
         chk(wait_o == (m_ready && adv_n), "R4 wait_o", 32'(wait_o), 32'(m_ready && adv_n));
         chk(proto_err == m_proto, "R8 proto_err", 32'(proto_err), 32'(m_proto));
         chk(tmo_err == m_tmo, "R9 tmo_err", 32'(tmo_err), 32'(m_tmo));
      end
   end

   task automatic chk_mem(input string tag);
      for (int i = 0; i < 16; i++) begin
         rd_addr = AW'(i);
         #1;
         chk(rd_data == mm[i], tag, 32'(rd_data), 32'(mm[i]));
      end
   endtask

   // advpat bit j: adv_n low at cycle j; ubm/lbm bit k: byte masked on beat k
   task automatic burst(input logic [AW-1:0] a, input logic [15:0] advpat, input bit we,
                        input logic [3:0] ubm, input logic [3:0] lbm, input int ncyc,
                        input logic [15:0] seed);
      for (int j = 0; j < ncyc; j++) begin
         int b;
         b = j - LAT;
         cs_n  = 1'b0;
         adv_n = (j < 16) ? !advpat[j] : 1'b1;
         we_n  = !we;
         addr  = (j == 0) ? a : (a ^ AW'(8));
         if (b >= 0 && b < BL) begin ub_n = ubm[b]; lb_n = lbm[b]; end
         else begin ub_n = 1'b1; lb_n = 1'b1; end
         din = seed + 16'(j);
         @(posedge clk); #3;
      end
      cs_n = 1'b1; adv_n = 1'b1; we_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1;
      repeat (2) begin @(posedge clk); #3; end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;
      // R11: reset state
      chk(wait_o == 1'b0, "R11 wait_o after reset", 32'(wait_o), 32'd0);
      chk(proto_err == 1'b0 && tmo_err == 1'b0, "R11 flags after reset",
          {30'd0, proto_err, tmo_err}, 32'd0);
      chk(wait_oe == 1'b0, "R3 released while deselected", 32'(wait_oe), 32'd0);
      chk_mem("R11 array zero");
      @(posedge clk); #3;

      // R2: plain burst, words 4..7 take data from edges 5..8
      burst(4'd4, 16'h0001, 1'b1, 4'b0000, 4'b0000, 9, 16'hA000);
      chk(mm[4] == 16'hA005 && mm[7] == 16'hA008, "R2 model sanity", 32'(mm[4]), 32'hA005);
      chk_mem("R2 plain burst / R12 read port");

      // R5 and R6: start at 6 (wraps 6,7,4,5), beat1 upper masked, beat2 fully masked
      burst(4'd6, 16'h0001, 1'b1, 4'b0110, 4'b0100, 9, 16'hB000);
      chk_mem("R5 R6 masks and wrap");

      // R1: adv held low three edges, address changed after the first
      burst(4'd8, 16'h0007, 1'b1, 4'b0000, 4'b0000, 9, 16'hC000);
      chk_mem("R1 held strobe");

      // R7: chip-select drops after two beats
      burst(4'd12, 16'h0001, 1'b1, 4'b0000, 4'b0000, 7, 16'hD000);
      rd_addr = 4'd14; #1;
      chk(rd_data == 16'h0000, "R7 dropped beat", 32'(rd_data), 32'd0);
      chk_mem("R7 abort");

      // R10: read-type strobe writes nothing
      burst(4'd0, 16'h0001, 1'b0, 4'b0000, 4'b0000, 9, 16'hE000);
      rd_addr = 4'd0; #1;
      chk(rd_data == 16'h0000, "R10 no write", 32'(rd_data), 32'd0);
      chk_mem("R10 array untouched");

      // R8: second strobe during latency is ignored and flagged
      chk(tmo_err == 1'b0, "R9 no early timeout", 32'(tmo_err), 32'd0);
      burst(4'd0, 16'h0009, 1'b1, 4'b0000, 4'b0000, 9, 16'hF000);
      chk(proto_err == 1'b1, "R8 overlap flagged", 32'(proto_err), 32'd1);
      chk_mem("R8 burst unaffected");

      // R9: chip-select held low past the limit
      burst(4'd8, 16'h0001, 1'b1, 4'b0000, 4'b0000, TMO + 15, 16'h1000);
      chk(tmo_err == 1'b1, "R9 timeout flagged", 32'(tmo_err), 32'd1);
      chk_mem("R9 data intact");

      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule